// File: doc/BRIEF.md
# Mailbox Virtual Register Bridge

This block is the device-side agent behind a small host I/O window of ten byte addresses. The host never sees the internal register space directly. To reach one byte of it, the host fills a short packet in a mailbox buffer and then rings a doorbell. The packet holds a command byte, an entry count, an optional data byte and a 16-bit virtual address. After a fixed, parameterised number of clock cycles the bridge performs the access against an internal byte-wide register file. It then reports the outcome in two places: a completion flag and a status code. The host clears both by writing ones.

Packet bytes go in through an auto-addressed data port that follows a 16-bit mailbox pointer, or through dedicated aliases for the count and the address bytes. The bridge also supports reading 16-bit quantities coherently. A read of the low byte of an even/odd pair takes a snapshot of the high byte, and the very next read of the high byte returns that snapshot, even if the live register changed in between.

Top module: `vrb_bridge`

## Requirements
- R1: After reset every window offset (0 to 9) reads 0x00.
- R2: Offsets 2 and 3 hold the low and high bytes of the mailbox pointer. Pointer 0x8000 addresses mailbox byte 0, the command. A write to offset 4 stores into mailbox byte [pointer low] and then increments the pointer low byte; a read of offset 4 returns that byte and leaves the pointer unchanged. Offsets 5, 6 and 7 read and write mailbox bytes 1 (entry count), 2 (address low) and 3 (address high).
- R3: Writing 0x01 to offset 0 while idle starts a command. Offset 0 then reads 0x01 while the command is busy. The result becomes visible exactly LATENCY clock edges after the edge that took the doorbell, and offset 0 reads 0x00 again from that point.
- R4: A doorbell write made while busy does not restart or shift the countdown. A write to offset 0 of any value other than 0x01 starts nothing.
- R5: Command 0x03 with count 0x01 stores mailbox byte 4 into the virtual register at the packet address. Command 0x02 with count 0x01 places that register's value in mailbox byte 4, which can be read at offset 4 with the pointer at 0x8004.
- R6: On completion, bit 0 of offset 8 becomes 1 and offset 1 takes the status code; the success code is 0x01. Writing ones to offset 8 or offset 1 clears the bits written, and writing zeros leaves them unchanged.
- R7: An address outside the range VBASE to VBASE+VDEPTH-1 reads as 0x00 and ignores writes, but the command still completes with status 0x01.
- R8: A command byte other than 0x02 or 0x03, or a count other than 0x01, completes with status 0x80 and bit 0 of offset 8 set, and no register changes.
- R9: A successful read at an even offset from VBASE latches the value of the next register. A read at that next address that directly follows it (writes in between are allowed) returns the latched value and drops the latch. Any other read also drops the latch.
- R10: When the pointer high byte is not 0x80, or the pointer low byte is past the mailbox, a write to offset 4 is ignored (no store, no pointer step) and a read of offset 4 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Window offset of the host access |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the offset on host_addr, combinational |

## Verification
A countdown that starts late, restarts, or stops one cycle off moves the edge on which offset 0 drops and offset 8 bit 0 rises. The bench samples that edge with no slack, so such a fault shows within the first command. A mailbox byte sent to the wrong index or a stale snapshot appears as a wrong byte at offset 4, one command later. A latch that survives too long or dies too early shows as the old or new value on the second of two reads at the odd address. A flag that misses a set or a clear shows directly at offsets 1 and 8 on the next read.

// File: rtl/vrb_pkg.sv
package vrb_pkg;

  localparam logic [3:0] OFS_BELL = 4'd0;
  localparam logic [3:0] OFS_STAT = 4'd1;
  localparam logic [3:0] OFS_PTRL = 4'd2;
  localparam logic [3:0] OFS_PTRH = 4'd3;
  localparam logic [3:0] OFS_DATA = 4'd4;
  localparam logic [3:0] OFS_CNT  = 4'd5;
  localparam logic [3:0] OFS_ADRL = 4'd6;
  localparam logic [3:0] OFS_ADRH = 4'd7;
  localparam logic [3:0] OFS_IRQ  = 4'd8;

  localparam logic [7:0] OP_READ    = 8'h02;
  localparam logic [7:0] OP_WRITE   = 8'h03;
  localparam logic [7:0] RING_VALUE = 8'h01;
  localparam logic [7:0] ST_OK      = 8'h01;
  localparam logic [7:0] ST_BAD     = 8'h80;
  localparam logic [7:0] REGION_HI  = 8'h80;
  localparam int         RES_BYTE   = 4;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  cnt;
    logic [15:0] addr;
    logic [7:0]  data;
  } pkt_t;

  function automatic logic pkt_ok(input pkt_t p);
    return ((p.op == OP_READ) || (p.op == OP_WRITE)) && (p.cnt == 8'h01);
  endfunction

  function automatic logic in_file(input logic [15:0] a, input logic [15:0] base,
                                   input int unsigned depth);
    return (32'(a) >= 32'(base)) && (32'(a) < (32'(base) + depth));
  endfunction

  function automatic logic [7:0] w1c(input logic [7:0] cur, input logic [7:0] ones);
    return cur & ~ones;
  endfunction

endpackage

// File: rtl/vrb_window.sv
module vrb_window
  import vrb_pkg::*;
#(
  parameter int MBOX_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       busy,
  input  logic       done,
  input  logic [7:0] done_status,
  input  logic [7:0] done_rdata,
  input  logic       done_is_read,
  output logic       bell_req,
  output pkt_t       pkt
);

  localparam int IDX_W = $clog2(MBOX_BYTES);

  logic [15:0]      ptr;
  logic [7:0]       ec2h;
  logic [7:0]       isr;
  logic [7:0]       isr_next;
  logic [7:0]       mbox [MBOX_BYTES];
  logic [IDX_W-1:0] dp_idx;
  logic             dp_valid;
  logic             dp_wr;
  logic [7:0]       dp_rdata;

  assign dp_idx   = ptr[IDX_W-1:0];
  assign dp_valid = (ptr[15:8] == REGION_HI) && (32'(ptr[7:0]) < 32'(MBOX_BYTES));
  assign dp_wr    = host_wr && (host_addr == OFS_DATA) && dp_valid;
  assign dp_rdata = dp_valid ? mbox[dp_idx] : 8'h00;
  assign bell_req = host_wr && (host_addr == OFS_BELL) && (host_wdata == RING_VALUE);

  // mailbox bytes: data-port store, fixed alias, engine result
  for (genvar i = 0; i < MBOX_BYTES; i++) begin : g_mbox
    localparam logic [3:0] ALIAS_OFS = 4'(4 + i);
    localparam bit         HAS_ALIAS = (i >= 1) && (i <= 3);
    localparam bit         IS_RES    = (i == RES_BYTE);
    logic [7:0] q;
    logic       we_host;
    logic       we_res;
    assign we_host = (dp_wr && (dp_idx == IDX_W'(i))) ||
                     (HAS_ALIAS && host_wr && (host_addr == ALIAS_OFS));
    assign we_res  = IS_RES && done && done_is_read;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 8'h00;
      else if (we_res)  q <= done_rdata;
      else if (we_host) q <= host_wdata;
    end
    assign mbox[i] = q;
  end

  assign pkt.op   = mbox[0];
  assign pkt.cnt  = mbox[1];
  assign pkt.addr = {mbox[3], mbox[2]};
  assign pkt.data = mbox[RES_BYTE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= 16'h0000;
    end else if (host_wr) begin
      case (host_addr)
        OFS_PTRL: ptr[7:0]  <= host_wdata;
        OFS_PTRH: ptr[15:8] <= host_wdata;
        OFS_DATA: if (dp_valid) ptr[7:0] <= ptr[7:0] + 8'd1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ec2h <= 8'h00;
    else if (done)                               ec2h <= done_status;
    else if (host_wr && host_addr == OFS_STAT)   ec2h <= w1c(ec2h, host_wdata);
  end

  always_comb begin
    isr_next = isr;
    if (host_wr && host_addr == OFS_IRQ) isr_next = w1c(isr, host_wdata);
    if (done) isr_next[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= 8'h00;
    else        isr <= isr_next;
  end

  always_comb begin
    case (host_addr)
      OFS_BELL: host_rdata = {7'd0, busy};
      OFS_STAT: host_rdata = ec2h;
      OFS_PTRL: host_rdata = ptr[7:0];
      OFS_PTRH: host_rdata = ptr[15:8];
      OFS_DATA: host_rdata = dp_rdata;
      OFS_CNT:  host_rdata = mbox[1];
      OFS_ADRL: host_rdata = mbox[2];
      OFS_ADRH: host_rdata = mbox[3];
      OFS_IRQ:  host_rdata = isr;
      default:  host_rdata = 8'h00;
    endcase
  end

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> isr[0]); // R6
  AST_STATUS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ec2h == $past(done_status))); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr |=> (ptr[7:0] == $past(ptr[7:0]) + 8'd1)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_DATA && !dp_valid) |=> $stable(ptr)); // R10

endmodule

// File: rtl/vrb_engine.sv
module vrb_engine
  import vrb_pkg::*;
#(
  parameter int LATENCY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bell_req,
  input  pkt_t pkt,
  output logic busy,
  output logic done,
  output pkt_t snap
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = bell_req && !busy;
  assign done   = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      snap <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(LATENCY);
      snap <= pkt;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt - CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((cnt != '0) && (32'(cnt) <= LATENCY))); // R3
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && (cnt == $past(cnt) - CNT_W'(1)))); // R4
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(snap)); // R4

endmodule

// File: rtl/vrb_regs.sv
module vrb_regs
  import vrb_pkg::*;
#(
  parameter logic [15:0] VBASE  = 16'h0580,
  parameter int          VDEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  pkt_t       cmd,
  output logic [7:0] rdata,
  output logic [7:0] status,
  output logic       is_read
);

  localparam int IDX_W = (VDEPTH > 1) ? $clog2(VDEPTH) : 1;

  logic [7:0]       regs [VDEPTH];
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             is_write;
  logic             pair_low;
  logic             shadow_v;
  logic [15:0]      shadow_a;
  logic [7:0]       shadow_d;
  logic             shadow_hit;

  assign hit        = in_file(cmd.addr, VBASE, VDEPTH);
  assign idx        = IDX_W'(cmd.addr - VBASE);
  assign is_read    = pkt_ok(cmd) && (cmd.op == OP_READ);
  assign is_write   = pkt_ok(cmd) && (cmd.op == OP_WRITE);
  assign pair_low   = hit && !idx[0] && ((32'(idx) + 32'd1) < 32'(VDEPTH));
  assign shadow_hit = shadow_v && (cmd.addr == shadow_a);
  assign status     = pkt_ok(cmd) ? ST_OK : ST_BAD;

  always_comb begin
    if (shadow_hit) rdata = shadow_d;
    else if (hit)   rdata = regs[idx];
    else            rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < VDEPTH; i++) regs[i] <= 8'h00;
    end else if (exec && is_write && hit) begin
      regs[idx] <= cmd.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_v <= 1'b0;
      shadow_a <= 16'h0000;
      shadow_d <= 8'h00;
    end else if (exec && is_read) begin
      if (!shadow_hit && pair_low) begin
        shadow_v <= 1'b1;
        shadow_a <= cmd.addr + 16'd1;
        shadow_d <= regs[IDX_W'(idx + IDX_W'(1))];
      end else begin
        shadow_v <= 1'b0;
      end
    end
  end

  AST_LATCH_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_v |-> (in_file(shadow_a, VBASE, VDEPTH) && (shadow_a[0] != VBASE[0]))); // R9
  AST_LATCH_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && is_read && shadow_hit) |=> !shadow_v); // R9
  AST_BAD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !pkt_ok(cmd)) |-> (status == ST_BAD)); // R8

endmodule

// File: rtl/vrb_bridge.sv
module vrb_bridge
  import vrb_pkg::*;
#(
  parameter int          LATENCY    = 6,
  parameter int          MBOX_BYTES = 8,
  parameter logic [15:0] VBASE      = 16'h0580,
  parameter int          VDEPTH     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);

  logic       busy;
  logic       done;
  logic       bell_req;
  pkt_t       pkt;
  pkt_t       snap;
  logic [7:0] res_data;
  logic [7:0] res_status;
  logic       res_is_read;

  vrb_window #(.MBOX_BYTES(MBOX_BYTES)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .busy         (busy),
    .done         (done),
    .done_status  (res_status),
    .done_rdata   (res_data),
    .done_is_read (res_is_read),
    .bell_req     (bell_req),
    .pkt          (pkt)
  );

  vrb_engine #(.LATENCY(LATENCY)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .bell_req (bell_req),
    .pkt      (pkt),
    .busy     (busy),
    .done     (done),
    .snap     (snap)
  );

  vrb_regs #(.VBASE(VBASE), .VDEPTH(VDEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec    (done),
    .cmd     (snap),
    .rdata   (res_data),
    .status  (res_status),
    .is_read (res_is_read)
  );

  AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_BELL) |-> (host_rdata == {7'd0, busy})); // R3

endmodule

// File: tb/tb_vrb_bridge.sv
`timescale 1ns/1ps
module tb_vrb_bridge;

  localparam int LAT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  vrb_bridge #(.LATENCY(LAT), .MBOX_BYTES(8), .VBASE(16'h0580), .VDEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic load_pkt(input logic [7:0] op, input logic [7:0] cnt,
                          input logic [15:0] va, input bit with_data, input logic [7:0] d);
    wr(4'd3, 8'h80); wr(4'd2, 8'h00);
    wr(4'd4, op); wr(4'd5, cnt);
    wr(4'd6, va[7:0]); wr(4'd7, va[15:8]);
    wr(4'd2, 8'h04);
    if (with_data) wr(4'd4, d);
  endtask

  // rings, checks exact completion edge, status, flags, clears them
  task automatic ring_check(input logic [7:0] exp_st, input string tag);
    logic [7:0] v;
    wr(4'd0, 8'h01);
    repeat (LAT - 1) @(posedge clk);
    #1;
    rd(4'd0, v); chk({"R3 busy before end ", tag}, v, 8'h01);
    rd(4'd8, v); chk({"R3 no flag before end ", tag}, v, 8'h00);
    @(posedge clk); #1;
    rd(4'd0, v); chk({"R3 idle at end ", tag}, v, 8'h00);
    rd(4'd8, v); chk({"R6 flag set ", tag}, v, 8'h01);
    rd(4'd1, v); chk({"R6 status ", tag}, v, exp_st);
    wr(4'd8, 8'h01); wr(4'd1, v);
    rd(4'd8, v); chk({"R6 flag cleared ", tag}, v, 8'h00);
    rd(4'd1, v); chk({"R6 status cleared ", tag}, v, 8'h00);
  endtask

  task automatic vwrite(input logic [15:0] va, input logic [7:0] d,
                        input logic [7:0] exp_st, input string tag);
    load_pkt(8'h03, 8'h01, va, 1'b1, d);
    ring_check(exp_st, tag);
  endtask

  task automatic vread(input logic [15:0] va, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    load_pkt(8'h02, 8'h01, va, 1'b0, 8'h00);
    ring_check(8'h01, tag);
    wr(4'd2, 8'h04);
    rd(4'd4, v); chk(tag, v, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v); chk("R1 reset value", v, 8'h00);
    end
  endtask

  task automatic t_mailbox;
    logic [7:0] v;
    wr(4'd3, 8'h80); wr(4'd2, 8'h00);
    wr(4'd4, 8'hAA); wr(4'd4, 8'hBB);
    rd(4'd2, v); chk("R2 pointer stepped", v, 8'h02);
    rd(4'd3, v); chk("R2 pointer high", v, 8'h80);
    wr(4'd2, 8'h00); rd(4'd4, v); chk("R2 byte0 via port", v, 8'hAA);
    rd(4'd2, v); chk("R2 read no step", v, 8'h00);
    wr(4'd2, 8'h01); rd(4'd4, v); chk("R2 byte1 via port", v, 8'hBB);
    rd(4'd5, v); chk("R2 count alias", v, 8'hBB);
    wr(4'd6, 8'h5A); wr(4'd2, 8'h02); rd(4'd4, v); chk("R2 addr low alias", v, 8'h5A);
  endtask

  task automatic t_outside_region;
    logic [7:0] v;
    wr(4'd3, 8'h00); wr(4'd2, 8'h00); wr(4'd4, 8'h55);
    rd(4'd2, v); chk("R10 no pointer step", v, 8'h00);
    rd(4'd4, v); chk("R10 reads zero", v, 8'h00);
    wr(4'd3, 8'h80); wr(4'd2, 8'h09); wr(4'd4, 8'h66);
    rd(4'd2, v); chk("R10 past mailbox no step", v, 8'h09);
    wr(4'd2, 8'h00); rd(4'd4, v); chk("R10 byte0 untouched", v, 8'hAA);
  endtask

  task automatic t_rw;
    vwrite(16'h0583, 8'h3C, 8'h01, "R5 write");
    vread(16'h0583, 8'h3C, "R5 readback");
    vwrite(16'h058F, 8'hE1, 8'h01, "R5 write top");
    vread(16'h058F, 8'hE1, "R5 readback top");
  endtask

  task automatic t_w1c_zero;
    logic [7:0] v;
    load_pkt(8'h02, 8'h01, 16'h0583, 1'b0, 8'h00);
    wr(4'd0, 8'h01);
    repeat (LAT) @(posedge clk);
    #1;
    wr(4'd8, 8'h00); wr(4'd1, 8'h00);
    rd(4'd8, v); chk("R6 zero write keeps flag", v, 8'h01);
    rd(4'd1, v); chk("R6 zero write keeps status", v, 8'h01);
    wr(4'd8, 8'h01); wr(4'd1, 8'h01);
  endtask

  task automatic t_bell_ignored;
    logic [7:0] v;
    load_pkt(8'h02, 8'h01, 16'h0583, 1'b0, 8'h00);
    wr(4'd0, 8'h01);
    @(posedge clk);
    wr(4'd0, 8'h01);
    repeat (LAT - 3) @(posedge clk);
    #1;
    rd(4'd0, v); chk("R4 still busy", v, 8'h01);
    @(posedge clk); #1;
    rd(4'd0, v); chk("R4 original end kept", v, 8'h00);
    rd(4'd8, v); chk("R4 flag at original end", v, 8'h01);
    wr(4'd8, 8'h01); wr(4'd1, 8'h01);
    wr(4'd0, 8'h02);
    rd(4'd0, v); chk("R4 other value no start", v, 8'h00);
    repeat (LAT + 2) @(posedge clk);
    #1;
    rd(4'd8, v); chk("R4 other value no flag", v, 8'h00);
  endtask

  task automatic t_out_of_range;
    vwrite(16'h1234, 8'h77, 8'h01, "R7 write outside");
    vread(16'h1234, 8'h00, "R7 read outside");
    vwrite(16'h0590, 8'h44, 8'h01, "R7 write past end");
    vread(16'h0590, 8'h00, "R7 read past end");
    vread(16'h057F, 8'h00, "R7 read below base");
  endtask

  task automatic t_bad_cmd;
    load_pkt(8'h05, 8'h01, 16'h0583, 1'b1, 8'h99);
    ring_check(8'h80, "R8 bad command");
    vwrite(16'h0583, 8'h11, 8'h01, "R8 dummy");
    vwrite(16'h0583, 8'h3C, 8'h01, "R8 restore");
    load_pkt(8'h03, 8'h02, 16'h0583, 1'b1, 8'h22);
    ring_check(8'h80, "R8 bad count");
    vread(16'h0583, 8'h3C, "R8 register unchanged");
  endtask

  task automatic t_latch;
    vwrite(16'h0584, 8'h10, 8'h01, "R9 setup low");
    vwrite(16'h0585, 8'h20, 8'h01, "R9 setup high");
    vread(16'h0584, 8'h10, "R9 low read");
    vwrite(16'h0585, 8'h99, 8'h01, "R9 change high");
    vread(16'h0585, 8'h20, "R9 latched high");
    vread(16'h0585, 8'h99, "R9 latch dropped");
    vread(16'h0584, 8'h10, "R9 low again");
    vread(16'h0583, 8'h3C, "R9 other read");
    vwrite(16'h0585, 8'h5E, 8'h01, "R9 change high again");
    vread(16'h0585, 8'h5E, "R9 latch dropped by other read");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_mailbox();
    t_outside_region();
    t_rw();
    t_w1c_zero();
    t_bell_ignored();
    t_out_of_range();
    t_bad_cmd();
    t_latch();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule